// File: doc/BRIEF.md
# Partitioned SIMD Unsigned Comparator

This block compares two wide operands that are divided into equal lanes, where the grouping of lanes into partitions is chosen at run time by a vector of cut bits. There is one cut bit at each internal lane boundary. Cut bit k sits between lane k and lane k+1. A set bit keeps the two lanes apart. A cleared bit joins them into one wider number, and the higher lane holds the more significant bits.

For every partition the block evaluates one relation on the matching slices of both operands. The relation is chosen by a 3-bit select input and is one of: equal, not equal, greater, greater-or-equal, less, or less-or-equal. All magnitude relations are unsigned. The single-bit answer for a partition is written to every output bit of the lanes that the partition covers, so downstream logic can use the result as a per-lane mask.

The block is purely combinational. It has no clock and no reset.

Top module: `simd_part_cmp`

## Requirements
- R1: With all cut bits set (`lane_cut` = 7'h7F), output bit i reflects the relation between byte i of `opnd_a` and byte i of `opnd_b`.
- R2: A cleared cut bit k joins lane k and lane k+1 into one partition. The partition is compared as a single unsigned number, with the higher lane most significant.
- R3: Every output bit of a partition carries that partition's single result.
- R4: `rel_sel` = 0 selects equal and `rel_sel` = 1 selects not equal.
- R5: `rel_sel` = 2 selects greater and `rel_sel` = 3 selects greater-or-equal, both unsigned (8'h80 is greater than 8'h7F).
- R6: `rel_sel` = 4 selects less and `rel_sel` = 5 selects less-or-equal, both unsigned.
- R7: `rel_sel` = 6 or 7 drives `lane_hit` to all zeros, whatever the operands and cuts are.
- R8: A partition may begin at any lane. A partition of lanes 3 to 5 (`lane_cut` = 7'h67) compares bits 47:24 as one 24-bit number.
- R9: With all cut bits cleared, both operands are compared as 64-bit numbers, and the result is repeated on all 8 output bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | First operand, with lane i at bits 8i+7:8i |
| opnd_b | input | 64 | Second operand, with the same lane layout |
| lane_cut | input | 7 | Bit k set separates lane k from lane k+1 |
| rel_sel | input | 3 | Relation select code |
| lane_hit | output | 8 | Per-lane result, repeated across each partition |

## Verification
The hardest case to reach is a partition in which the lanes disagree. For example, a lower lane of the partition compares greater while a higher lane compares less, so the answer comes from the upper lane alone. The same case must also start at a lane other than zero.

Random operands almost never make the upper bytes of a partition equal. Because of this, the directed table builds partitions that start in the middle of the word. Within those partitions, it places equal, greater and less bytes at chosen positions.

A random sweep then covers the other cut patterns. It checks every result against a model that walks the partitions and computes each partition's relation on its own.

// File: rtl/simd_cmp_pkg.sv
// Package: shared sizes and relation codes for the partitioned comparator.
// Assumes the lane count is at least 2.
package simd_cmp_pkg;
    localparam int unsigned LANES_DEF  = 8;
    localparam int unsigned LANE_W_DEF = 8;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_GT = 3'd2,
        REL_GE = 3'd3,
        REL_LT = 3'd4,
        REL_LE = 3'd5
    } rel_code_e;
endpackage

// File: rtl/simd_lane_cmp.sv
// Module: per-lane unsigned compare. For each lane it gives equal and
// greater flags for the lane's slice of both operands.
// Assumes: operands are packed lane by lane, with lane 0 in the low bits.
module simd_lane_cmp #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned TOT_W = LANES * LANE_W
) (
    input  logic [TOT_W-1:0] a_i,
    input  logic [TOT_W-1:0] b_i,
    output logic [LANES-1:0] eq_o,
    output logic [LANES-1:0] gt_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] sa, sb;
        assign sa = a_i[i*LANE_W +: LANE_W];
        assign sb = b_i[i*LANE_W +: LANE_W];
        assign eq_o[i] = (sa == sb);
        assign gt_o[i] = (sa > sb);
    end
endmodule

// File: rtl/simd_merge_chain.sv
// Module: combines the lane flags from the top of each partition downward.
// At every lane it gives the equal and greater flags for the span from that
// lane up to the top of its partition. At a partition's first lane, these
// flags describe the whole partition.
// Assumes: cut bit k separates lane k from lane k+1.
module simd_merge_chain #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] lane_eq_i,
    input  logic [LANES-1:0] lane_gt_i,
    input  logic [LANES-2:0] cut_i,
    output logic [LANES-1:0] span_eq_o,
    output logic [LANES-1:0] span_gt_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_chain
        if (i == LANES - 1) begin : g_top
            // Purpose: the topmost lane is always the top of its partition.
            assign span_eq_o[i] = lane_eq_i[i];
            assign span_gt_o[i] = lane_gt_i[i];
        end else begin : g_mid
            // Purpose: restart at a cut; otherwise the upper span decides
            // unless it is equal.
            assign span_eq_o[i] = lane_eq_i[i] & (cut_i[i] | span_eq_o[i+1]);
            assign span_gt_o[i] = cut_i[i] ? lane_gt_i[i]
                                : (span_gt_o[i+1] | (span_eq_o[i+1] & lane_gt_i[i]));
        end
    end

    // Purpose: a span can never be both equal and greater (guards R2).
    always_comb begin
        p_span_excl_r2: assert ((span_eq_o & span_gt_o) == '0)
            else $error("span flagged equal and greater at once");
    end
endmodule

// File: rtl/simd_pred_spread.sv
// Module: turns each partition's span flags into the chosen relation and
// copies the result over every lane of the partition.
// Assumes: the span flags are valid at each partition's first lane.
module simd_pred_spread #(
    parameter int unsigned LANES = 8
) (
    input  logic [LANES-1:0] span_eq_i,
    input  logic [LANES-1:0] span_gt_i,
    input  logic [LANES-2:0] cut_i,
    input  logic [2:0]       rel_i,
    output logic [LANES-1:0] hit_o
);
    import simd_cmp_pkg::*;

    logic [LANES-1:0] pred;

    // Purpose: work out the chosen relation at every lane.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            unique case (rel_i)
                REL_EQ:  pred[i] = span_eq_i[i];
                REL_NE:  pred[i] = ~span_eq_i[i];
                REL_GT:  pred[i] = span_gt_i[i];
                REL_GE:  pred[i] = span_gt_i[i] | span_eq_i[i];
                REL_LT:  pred[i] = ~(span_gt_i[i] | span_eq_i[i]);
                REL_LE:  pred[i] = ~span_gt_i[i];
                default: pred[i] = 1'b0;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_spread
        if (i == 0) begin : g_first
            // Purpose: lane 0 always starts a partition.
            assign hit_o[i] = pred[i];
        end else begin : g_rest
            // Purpose: a partition's first lane sets the value; the lanes above it copy it.
            assign hit_o[i] = cut_i[i-1] ? pred[i] : hit_o[i-1];
        end
    end

    // Purpose: lanes joined by a cleared cut show the same result (R3).
    always_comb begin
        for (int i = 1; i < LANES; i++) begin
            p_part_uniform_r3: assert (cut_i[i-1] || (hit_o[i] == hit_o[i-1]))
                else $error("lanes %0d and %0d of one partition differ", i-1, i);
        end
    end
endmodule

// File: rtl/simd_part_cmp.sv
// Module: top of the partitioned SIMD unsigned comparator. It compares two
// operands under a run-time partition set by the cut bits. Each partition's
// single result is repeated across its lanes. The block is purely
// combinational.
// Assumes: unsigned operands; select codes above 5 give all zeros.
module simd_part_cmp #(
    parameter int unsigned LANES  = simd_cmp_pkg::LANES_DEF,
    parameter int unsigned LANE_W = simd_cmp_pkg::LANE_W_DEF,
    localparam int unsigned TOT_W = LANES * LANE_W
) (
    input  logic [TOT_W-1:0] opnd_a,
    input  logic [TOT_W-1:0] opnd_b,
    input  logic [LANES-2:0] lane_cut,
    input  logic [2:0]       rel_sel,
    output logic [LANES-1:0] lane_hit
);
    logic [LANES-1:0] lane_eq, lane_gt, span_eq, span_gt;

    simd_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .eq_o (lane_eq),
        .gt_o (lane_gt)
    );

    simd_merge_chain #(.LANES(LANES)) u_chain (
        .lane_eq_i (lane_eq),
        .lane_gt_i (lane_gt),
        .cut_i     (lane_cut),
        .span_eq_o (span_eq),
        .span_gt_o (span_gt)
    );

    simd_pred_spread #(.LANES(LANES)) u_spread (
        .span_eq_i (span_eq),
        .span_gt_i (span_gt),
        .cut_i     (lane_cut),
        .rel_i     (rel_sel),
        .hit_o     (lane_hit)
    );

    // Purpose: unused select codes give a zero output (R7).
    always_comb begin
        p_bad_sel_zero_r7: assert (rel_sel <= 3'd5 || lane_hit == '0)
            else $error("unused select code gave nonzero output");
    end

    // Purpose: a single full-width partition under equal matches a whole-word compare (R9).
    always_comb begin
        p_full_eq_r9: assert (lane_cut != '0 || rel_sel != 3'd0
                              || lane_hit == {LANES{opnd_a == opnd_b}})
            else $error("full-width equal mismatch");
    end
endmodule

// File: tb/simd_part_cmp_tb_top.sv
// Bench: a table of directed vectors, then directed corner cases, then a
// random sweep checked against a model that walks the partitions.
module simd_part_cmp_tb_top;
    localparam int ROWS = 11;
    localparam int VW   = 64 + 64 + 7 + 3 + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a, opnd_b;
    logic [6:0]  lane_cut;
    logic [2:0]  rel_sel;
    logic [7:0]  lane_hit;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    simd_part_cmp dut_i (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .lane_cut (lane_cut),
        .rel_sel  (rel_sel),
        .lane_hit (lane_hit)
    );

    // Rows are {a, b, cut, sel, expected}.
    localparam logic [VW-1:0] VEC [ROWS] = '{
        {64'h0102030405060708, 64'h0102030405060708, 7'h7F, 3'd0, 8'hFF},
        {64'h0102030405060708, 64'h0102030405060708, 7'h7F, 3'd1, 8'h00},
        {64'h00000000000000FF, 64'h0000000000000100, 7'h00, 3'd2, 8'h00},
        {64'h00000000000000FF, 64'h0000000000000100, 7'h00, 3'd4, 8'hFF},
        {64'h00000000000000FF, 64'h0000000000000100, 7'h7F, 3'd2, 8'h01},
        {64'h00000000000000FF, 64'h0000000000000100, 7'h7F, 3'd3, 8'hFD},
        {64'h0000100000000000, 64'h00000F00FF000000, 7'h67, 3'd2, 8'h38},
        {64'h0000100000000000, 64'h00000F00FF000000, 7'h67, 3'd5, 8'hC7},
        {64'h0000000000000080, 64'h000000000000007F, 7'h7F, 3'd2, 8'h01},
        {64'h0000000000000001, 64'h0000000000000001, 7'h7F, 3'd6, 8'h00},
        {64'h0000000000000001, 64'h0000000000000002, 7'h00, 3'd7, 8'h00}
    };

    function automatic string row_tag(int r);
        case (r)
            0:       return "R1 R4 equal per lane";
            1:       return "R4 not equal";
            2:       return "R9 full-width greater";
            3:       return "R9 R6 full-width less";
            4:       return "R1 R5 per-lane greater";
            5:       return "R5 per-lane greater-or-equal";
            6:       return "R8 R3 offset partition greater";
            7:       return "R8 R6 offset partition less-or-equal";
            8:       return "R5 unsigned 80 vs 7F";
            9:       return "R7 select 6";
            default: return "R7 select 7";
        endcase
    endfunction

    // Model: walk the partitions, compare each one on its own, fill its lanes.
    function automatic logic [7:0] model(logic [63:0] a, logic [63:0] b,
                                         logic [6:0] cut, logic [2:0] sel);
        logic [7:0] r = '0;
        int s = 0;
        while (s < 8) begin
            int e = s;
            logic [63:0] va, vb;
            logic p;
            while (e < 7 && !cut[e]) e++;
            va = '0; vb = '0;
            for (int k = e; k >= s; k--) begin
                va = (va << 8) | 64'(a[k*8 +: 8]);
                vb = (vb << 8) | 64'(b[k*8 +: 8]);
            end
            case (sel)
                3'd0: p = (va == vb);
                3'd1: p = (va != vb);
                3'd2: p = (va > vb);
                3'd3: p = (va >= vb);
                3'd4: p = (va < vb);
                3'd5: p = (va <= vb);
                default: p = 1'b0;
            endcase
            for (int k = s; k <= e; k++) r[k] = p;
            s = e + 1;
        end
        return r;
    endfunction

    task automatic apply_check(logic [63:0] a, logic [63:0] b, logic [6:0] cut,
                               logic [2:0] sel, logic [7:0] exp, string tag);
        @(negedge clk);
        opnd_a = a; opnd_b = b; lane_cut = cut; rel_sel = sel;
        #1;
        n_checks++;
        if (lane_hit !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h (a=%016h b=%016h cut=%02h sel=%0d)",
                     tag, lane_hit, exp, a, b, cut, sel);
        end
    endtask

    initial begin
        opnd_a = '0; opnd_b = '0; lane_cut = '0; rel_sel = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: zero operands under equal give all ones (R9).
        apply_check('0, '0, 7'h00, 3'd0, 8'hFF, "R9 initial zero inputs");
        for (int r = 0; r < ROWS; r++) begin
            logic [VW-1:0] v = VEC[r];
            apply_check(v[145:82], v[81:18], v[17:11], v[10:8], v[7:0], row_tag(r));
        end
        // R2: lower lane greater, upper lane less; the joined pair compares less.
        apply_check(64'h00FF, 64'h0100, 7'h7E, 3'd2, 8'h00, "R2 joined pair greater");
        apply_check(64'h00FF, 64'h0100, 7'h7E, 3'd4, 8'h03, "R2 joined pair less");
        // R3 R8: a partition of lanes 5..7 with the top byte decisive.
        apply_check(64'h0200000000000000, 64'h01FFFF0000000000, 7'h1F, 3'd3, 8'hFF,
                    "R3 R8 upper partition greater-or-equal");
        // R7: an unused code with a full-width partition of unequal operands.
        apply_check(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'h00, 3'd6, 8'h00, "R7 select 6 full width");
        // Random sweep against the model.
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [6:0]  c = 7'($urandom);
            logic [2:0]  s = 3'($urandom);
            // Make some upper bytes equal so the lower bytes can decide.
            if (n % 3 == 0) b = (b & 64'h00000000FFFFFFFF) | (a & 64'hFFFFFFFF00000000);
            apply_check(a, b, c, s, model(a, b, c, s), "R2 R3 random sweep");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule